// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts the direction of conditional branches for an instruction fetch pipeline. It keeps a short shift register of the most recent resolved branch outcomes. It also keeps a table of small saturating counters. The table index puts low-order word-address bits of the branch PC above the history bits. The PC bits therefore select a row, and the history picks one of the 2^m counters inside that row. Branches whose direction depends on the outcome of earlier branches can then train separate counters for each recent pattern.

Fetch presents a PC on the lookup port and receives a taken / not-taken prediction in the same cycle. The block also shows its current history, so fetch can keep that value with the branch. When the branch resolves, the pipeline sends back the PC, the real outcome and the history value it kept. The block trains the counter that this snapshot selects and shifts the outcome into the live history. A restore port lets a flush load a known history value directly. There are no tags, so branches that share the indexed PC bits share counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: After a synchronous active-low reset the history reads 0 and every counter holds the weakly-not-taken value 2^(n-1)-1, so every lookup predicts not taken.
- R2: A lookup predicts taken exactly when the selected counter is at least 2^(n-1), that is greater than half of its maximum 2^n-1. The prediction appears on `lk_taken` in the same cycle as `lk_pc`, with 1 meaning taken.
- R3: An update with `up_taken`=1 increments the selected counter and holds it at 2^n-1 once it is there.
- R4: An update with `up_taken`=0 decrements the selected counter and holds it at 0 once it is there.
- R5: The table index is {pc[PC_IDX_BITS+1:2], hist}, with the history in the low bits. PC bits [1:0] and all PC bits above PC_IDX_BITS+1 are ignored, so PCs that differ only there alias to the same counters.
- R6: Each update shifts `up_taken` into bit 0 of the history and drops the oldest bit (new history = {old[m-2:0], outcome}). With no update and no restore, the history holds its value.
- R7: An update trains the counter selected by `up_pc` and the supplied snapshot `up_hist`, not by the live history. Counters of other history values in that row are left unchanged.
- R8: When a lookup and an update select the same counter in the same cycle, the lookup returns the counter value from before the update. The new value is seen from the next cycle.
- R9: A restore loads `hr_hist` into the history on the next edge. If it comes in the same cycle as an update, the restore value wins over the shift, and the counter is still trained.
- R10: With 2-bit counters, a branch at the strongly taken state keeps predicting taken after one not-taken outcome. It flips to not taken only after a second not-taken outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_WIDTH | PC of the instruction being fetched |
| lk_taken | output | 1 | Same-cycle prediction, 1 = taken |
| lk_hist | output | HIST_BITS | Current global history, for the fetch unit to keep with the branch |
| up_valid | input | 1 | A resolved branch is being reported this cycle |
| up_pc | input | PC_WIDTH | PC of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_hist | input | HIST_BITS | History snapshot taken when this branch was predicted |
| hr_valid | input | 1 | Load the history from `hr_hist` |
| hr_hist | input | HIST_BITS | History value to restore |

## Verification
The assertions assume that `up_pc`, `up_taken` and `up_hist` are meaningful whenever `up_valid` is high, and that `lk_pc` may change freely. They assume that nothing other than an update or a restore may change the prediction for a fixed lookup PC. The bench drives every input just after a falling edge and holds it through the next rising edge. It lowers `up_valid` and `hr_valid` once the edge has passed, so each report counts exactly once. Test entries are chosen so that each scenario starts from counters it has not touched before. A shadow table, built only from the requirements, gives the expected prediction for each lookup. Before each lookup the bench loads the history through the restore port, which lets it pick any counter in a row.

// File: rtl/bp_pkg.sv
// Package: shared types for the correlating branch predictor.
// Assumes: nothing; holds only encodings that several modules use.
package bp_pkg;

    // Direction of a branch, used for both predictions and outcomes.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

endpackage

// File: rtl/bp_global_history.sv
// Module: bp_global_history
// Holds the outcomes of the last HIST_BITS resolved branches. The newest
// outcome is in bit 0. A restore load takes priority over a shift in the
// same cycle.
// Assumes: HIST_BITS >= 1; load_val is valid whenever load_en is high.
module bp_global_history #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 load_en,
    input  logic [HIST_BITS-1:0] load_val,
    output logic [HIST_BITS-1:0] hist_q
);

    logic [HIST_BITS-1:0] shifted;

    // Next history after a shift; a one-bit history is just the outcome.
    generate
        if (HIST_BITS == 1) begin : g_single
            always_comb shifted = shift_bit;
        end else begin : g_multi
            always_comb shifted = {hist_q[HIST_BITS-2:0], shift_bit};
        end
    endgenerate

    // History register: clear on reset, restore first, else shift on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (load_en) begin
            hist_q <= load_val;
        end else if (shift_en) begin
            hist_q <= shifted;
        end
    end

    // R6: an update without restore shifts the outcome into bit 0.
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=>
            hist_q == HIST_BITS'({$past(hist_q), $past(shift_bit)}));

    // R6: with no update and no restore, the history holds.
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(hist_q));

    // R9: a restore loads the given value, even if an update comes with it.
    p_hist_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> hist_q == $past(load_val));

endmodule

// File: rtl/bp_index_gen.sv
// Module: bp_index_gen
// Builds the counter-table index from a PC and a history value. Word-address
// bits above the byte offset form the row; the history bits sit below them
// and select a counter inside the row.
// Assumes: instructions are word aligned; PC_WIDTH > PC_IDX_BITS + 2.
module bp_index_gen #(
    parameter int PC_WIDTH    = 32,
    parameter int PC_IDX_BITS = 8,
    parameter int HIST_BITS   = 2,
    localparam int IDX_BITS   = PC_IDX_BITS + HIST_BITS
) (
    input  logic [PC_WIDTH-1:0]  pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [IDX_BITS-1:0]  idx
);

    logic unused_pc_bits;

    // Concatenate the row bits and the history bits into one index.
    always_comb idx = {pc[PC_IDX_BITS+1:2], hist};

    // Byte-offset and high PC bits do not take part (no tags).
    always_comb unused_pc_bits = ^{pc[PC_WIDTH-1:PC_IDX_BITS+2], pc[1:0]};

endmodule

// File: rtl/bp_sat_next.sv
// Module: bp_sat_next
// Next value of an n-bit saturating counter: one step up on taken, one step
// down on not taken, held at both ends.
// Assumes: CTR_BITS >= 1.
module bp_sat_next
    import bp_pkg::*;
#(
    parameter int CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                taken,
    output logic [CTR_BITS-1:0] nxt
);

    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
    localparam logic [CTR_BITS-1:0] CTR_MIN = '0;
    localparam logic [CTR_BITS-1:0] CTR_ONE = CTR_BITS'(1);

    dir_e dir;

    // Decode the outcome into the shared direction type.
    always_comb dir = dir_e'(taken);

    // Saturating step in the direction of the outcome.
    always_comb begin
        nxt = cur;
        if (dir == DIR_TAKEN) begin
            if (cur != CTR_MAX) nxt = cur + CTR_ONE;
        end else begin
            if (cur != CTR_MIN) nxt = cur - CTR_ONE;
        end
    end

endmodule

// File: rtl/bp_counter_table.sv
// Module: bp_counter_table
// Flop array of saturating counters with one combinational read port and one
// synchronous training port. A read of the entry being written in the same
// cycle returns the old value.
// Assumes: wr_idx and wr_taken are valid whenever wr_en is high.
module bp_counter_table #(
    parameter int IDX_BITS = 10,
    parameter int CTR_BITS = 2,
    localparam int DEPTH   = 1 << IDX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [CTR_BITS-1:0] rd_ctr,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_taken
);

    localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
    localparam logic [CTR_BITS-1:0] CTR_ONE  = CTR_BITS'(1);
    // Weakly not taken: one below the taken threshold.
    localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

    logic [CTR_BITS-1:0] ctr_q [DEPTH];
    logic [CTR_BITS-1:0] wr_old;
    logic [CTR_BITS-1:0] wr_nxt;

    // Read port: current contents, never the value being written.
    always_comb rd_ctr = ctr_q[rd_idx];

    // Old value of the entry being trained.
    always_comb wr_old = ctr_q[wr_idx];

    bp_sat_next #(
        .CTR_BITS (CTR_BITS)
    ) u_step (
        .cur   (wr_old),
        .taken (wr_taken),
        .nxt   (wr_nxt)
    );

    // Counter storage: weakly-not-taken on reset, one entry trained per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_INIT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_nxt;
        end
    end

    // R3: a taken update below the top moves the entry up by one.
    p_ctr_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old != CTR_MAX) |=>
            ctr_q[$past(wr_idx)] == $past(wr_old) + CTR_ONE);

    // R3: a taken update at the top leaves the entry at the top.
    p_ctr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_old == CTR_MAX) |=>
            ctr_q[$past(wr_idx)] == CTR_MAX);

    // R4: a not-taken update above zero moves the entry down by one.
    p_ctr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old != '0) |=>
            ctr_q[$past(wr_idx)] == $past(wr_old) - CTR_ONE);

    // R4: a not-taken update at zero leaves the entry at zero.
    p_ctr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_old == '0) |=>
            ctr_q[$past(wr_idx)] == '0);

    // R8: without a write, re-reading the same index returns the same value.
    p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_idx != $past(rd_idx) || rd_ctr == $past(rd_ctr)));

endmodule

// File: rtl/corr_branch_predictor.sv
// Module: corr_branch_predictor
// Two-level (m,n) branch predictor. The global history of the last m
// outcomes selects one of 2^m n-bit counters in the row picked by the
// low word-address bits of the PC. The lookup is combinational. Training
// and the history shift take effect on the next rising edge.
// Assumes: word-aligned PCs; the caller returns the lk_hist value it saw at
// prediction time as up_hist when the branch resolves.
module corr_branch_predictor #(
    parameter int PC_WIDTH    = 32,
    parameter int PC_IDX_BITS = 8,
    parameter int HIST_BITS   = 2,
    parameter int CTR_BITS    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_WIDTH-1:0]  lk_pc,
    output logic                 lk_taken,
    output logic [HIST_BITS-1:0] lk_hist,
    input  logic                 up_valid,
    input  logic [PC_WIDTH-1:0]  up_pc,
    input  logic                 up_taken,
    input  logic [HIST_BITS-1:0] up_hist,
    input  logic                 hr_valid,
    input  logic [HIST_BITS-1:0] hr_hist
);

    localparam int IDX_BITS = PC_IDX_BITS + HIST_BITS;

    logic [HIST_BITS-1:0] hist_q;
    logic [IDX_BITS-1:0]  lk_idx;
    logic [IDX_BITS-1:0]  up_idx;
    logic [CTR_BITS-1:0]  lk_ctr;

    bp_global_history #(
        .HIST_BITS (HIST_BITS)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (up_valid),
        .shift_bit (up_taken),
        .load_en   (hr_valid),
        .load_val  (hr_hist),
        .hist_q    (hist_q)
    );

    // Lookup uses the live history; update uses the snapshot it carries.
    bp_index_gen #(
        .PC_WIDTH    (PC_WIDTH),
        .PC_IDX_BITS (PC_IDX_BITS),
        .HIST_BITS   (HIST_BITS)
    ) u_lk_idx (
        .pc   (lk_pc),
        .hist (hist_q),
        .idx  (lk_idx)
    );

    bp_index_gen #(
        .PC_WIDTH    (PC_WIDTH),
        .PC_IDX_BITS (PC_IDX_BITS),
        .HIST_BITS   (HIST_BITS)
    ) u_up_idx (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    bp_counter_table #(
        .IDX_BITS (IDX_BITS),
        .CTR_BITS (CTR_BITS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    // Taken when the counter is in its upper half: its top bit is set.
    always_comb lk_taken = lk_ctr[CTR_BITS-1];

    // History is visible so fetch can keep it with the branch.
    always_comb lk_hist = hist_q;

    // R5: with no update or restore, the same PC keeps the same prediction.
    p_pred_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid && !hr_valid) |=>
            (lk_pc != $past(lk_pc) || lk_taken == $past(lk_taken)));

endmodule

// File: tb/tb_corr_branch_predictor.sv
`timescale 1ns/1ps
// Directed bench. A shadow counter table, built from the requirements,
// supplies the expected predictions.
module tb_corr_branch_predictor;

    localparam int PCW = 32;
    localparam int PIB = 8;
    localparam int HB  = 2;
    localparam int CB  = 2;
    localparam int NENT = 1 << (PIB + HB);
    localparam int CMAX = (1 << CB) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [PCW-1:0] lk_pc = '0;
    logic           lk_taken;
    logic [HB-1:0]  lk_hist;
    logic           up_valid = 1'b0;
    logic [PCW-1:0] up_pc = '0;
    logic           up_taken = 1'b0;
    logic [HB-1:0]  up_hist = '0;
    logic           hr_valid = 1'b0;
    logic [HB-1:0]  hr_hist = '0;

    int total = 0;
    int bad = 0;
    int ref_ctr [NENT];
    int ref_hist = 0;

    always #5 clk = ~clk;

    corr_branch_predictor #(
        .PC_WIDTH    (PCW),
        .PC_IDX_BITS (PIB),
        .HIST_BITS   (HB),
        .CTR_BITS    (CB)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .lk_hist  (lk_hist),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken),
        .up_hist  (up_hist),
        .hr_valid (hr_valid),
        .hr_hist  (hr_hist)
    );

    function automatic int ref_idx(logic [PCW-1:0] pc, int h);
        return (int'(pc[PIB+1:2]) << HB) | h;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Shadow training of one entry, following R3/R4.
    task automatic ref_train(logic [PCW-1:0] pc, int h, bit t);
        int i = ref_idx(pc, h);
        if (t) begin
            if (ref_ctr[i] < CMAX) ref_ctr[i]++;
        end else begin
            if (ref_ctr[i] > 0) ref_ctr[i]--;
        end
    endtask

    task automatic upd(logic [PCW-1:0] pc, bit t, int h);
        up_valid = 1'b1; up_pc = pc; up_taken = t; up_hist = HB'(h);
        step();
        up_valid = 1'b0;
        ref_train(pc, h, t);
        ref_hist = ((ref_hist << 1) | int'(t)) & ((1 << HB) - 1);
    endtask

    task automatic restore(int h);
        hr_valid = 1'b1; hr_hist = HB'(h);
        step();
        hr_valid = 1'b0;
        ref_hist = h;
    endtask

    // Select a counter via restore + lookup PC, then compare the prediction.
    task automatic check_pred(string req, logic [PCW-1:0] pc, int h);
        restore(h);
        lk_pc = pc;
        #1;
        check(req, int'(lk_taken), int'(ref_ctr[ref_idx(pc, h)] >= (1 << (CB - 1))));
    endtask

    task automatic t_reset();
        check("R1 history after reset", int'(lk_hist), 0);
        lk_pc = 32'h0000_0000; #1;
        check("R1 pc0 not taken", int'(lk_taken), 0);
        lk_pc = 32'h0000_03FC; #1;
        check("R1 last row not taken", int'(lk_taken), 0);
        check_pred("R1 hist3 not taken", 32'h0000_0040, 3);
    endtask

    task automatic t_sat_up();
        for (int k = 0; k < 5; k++) upd(32'h0000_0100, 1'b1, 1);
        check_pred("R3 saturated high predicts taken", 32'h0000_0100, 1);
        check("R3 model at max", ref_ctr[ref_idx(32'h100, 1)], CMAX);
        upd(32'h0000_0100, 1'b0, 1);
        check_pred("R10 one miss keeps taken", 32'h0000_0100, 1);
        upd(32'h0000_0100, 1'b0, 1);
        check_pred("R10 second miss flips", 32'h0000_0100, 1);
    endtask

    task automatic t_sat_down();
        for (int k = 0; k < 4; k++) upd(32'h0000_0200, 1'b0, 2);
        check_pred("R4 floor predicts not taken", 32'h0000_0200, 2);
        upd(32'h0000_0200, 1'b1, 2);
        check_pred("R4 one step up from zero still not taken", 32'h0000_0200, 2);
        upd(32'h0000_0200, 1'b1, 2);
        check_pred("R2 threshold reached predicts taken", 32'h0000_0200, 2);
    endtask

    task automatic t_alias();
        upd(32'h0000_0080, 1'b1, 0);
        upd(32'h0000_0080, 1'b1, 0);
        check_pred("R5 byte offset 1 ignored", 32'h0000_0081, 0);
        check_pred("R5 byte offset 3 ignored", 32'h0000_0083, 0);
        check_pred("R5 high bit aliases", 32'h0000_0480, 0);
        check_pred("R5 next row separate", 32'h0000_0084, 0);
        check_pred("R5 other history separate", 32'h0000_0080, 1);
    endtask

    task automatic t_history();
        restore(0);
        upd(32'h0000_0300, 1'b1, 0);
        check("R6 shift in taken", int'(lk_hist), ref_hist);
        upd(32'h0000_0300, 1'b0, 0);
        check("R6 shift in not taken", int'(lk_hist), ref_hist);
        upd(32'h0000_0300, 1'b1, 0);
        check("R6 oldest dropped", int'(lk_hist), 1);
        step();
        check("R6 hold without update", int'(lk_hist), 1);
    endtask

    task automatic t_snapshot();
        restore(3);
        upd(32'h0000_0010, 1'b1, 0);
        upd(32'h0000_0010, 1'b1, 0);
        check_pred("R7 snapshot entry trained", 32'h0000_0010, 0);
        check_pred("R7 live-history entry untouched", 32'h0000_0010, 3);
    endtask

    task automatic t_same_cycle();
        restore(2);
        lk_pc = 32'h0000_0020;
        up_valid = 1'b1; up_pc = 32'h0000_0020; up_taken = 1'b1; up_hist = 2'd2;
        #1;
        check("R8 same-cycle lookup sees old value", int'(lk_taken), 0);
        step();
        up_valid = 1'b0;
        ref_train(32'h0000_0020, 2, 1'b1);
        ref_hist = ((ref_hist << 1) | 1) & ((1 << HB) - 1);
        check_pred("R8 new value next cycle", 32'h0000_0020, 2);
    endtask

    task automatic t_restore();
        restore(0);
        up_valid = 1'b1; up_pc = 32'h0000_0030; up_taken = 1'b1; up_hist = 2'd1;
        hr_valid = 1'b1; hr_hist = 2'd2;
        step();
        up_valid = 1'b0; hr_valid = 1'b0;
        ref_train(32'h0000_0030, 1, 1'b1);
        ref_hist = 2;
        check("R9 restore wins over shift", int'(lk_hist), 2);
        check_pred("R9 counter still trained", 32'h0000_0030, 1);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) ref_ctr[i] = (1 << (CB - 1)) - 1;
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_sat_up();
        t_sat_down();
        t_alias();
        t_history();
        t_snapshot();
        t_same_cycle();
        t_restore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule